// File: doc/BRIEF.md
# ADC Input Channel Scan Sequencer

This block decides which analog input a single shared converter samples next. It holds two input selections, A and B. Each has a 5-bit positive channel code and a one-bit negative-input choice. A scan bitmap can replace the fixed positive code of selection A. When the scan is on, selection A walks through the marked channels in ascending order. When alternation is on, selection A and selection B take turns on successive conversions.

The block moves forward on a one-cycle conversion-complete pulse. It goes back to its start point on a one-cycle restart pulse, which the interrupt-threshold logic raises when the programmed number of conversions has been reached. The positive code and negative select it drives go straight to the analog multiplexer control. Bitmap positions 0 to 15 are the external inputs with codes 0 to 15. Positions 16 and 17 are two internal reference channels with codes 16 and 17.

Top module: `adc_scan_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `ch_pos` and `ch_neg` become 0, the scan position returns to its start and the next conversion uses selection A.
- R2: With `scan_en` low, every selection-A conversion drives `a_pos` and `a_neg`, whatever the conversion pulses do.
- R3: With `scan_en` high and a non-zero `scan_map`, selection A drives the index of a set bit in `scan_map` as its code (bit i gives code i). Successive selection-A conversions visit the set bits in ascending order and skip the clear bits.
- R4: After the highest set bit of `scan_map` has been converted, the scan wraps to the lowest set bit.
- R5: With `scan_en` high and `scan_map` all zero, selection A drives `a_pos`.
- R6: With `alt_en` high, successive conversions alternate A, B, A, B, starting with A. Selection B always drives `b_pos` and `b_neg`, even while scanning.
- R7: The scan position changes only on a `conv_done` pulse that ends a selection-A conversion. Idle cycles and the end of a selection-B conversion leave it unchanged.
- R8: A `seq_restart` pulse returns the scan to the lowest set bit and the next conversion to selection A. When `seq_restart` and `conv_done` arrive in the same cycle, the restart wins.
- R9: With `alt_en` low, every conversion uses selection A, including the one after alternation is switched off during a B turn.
- R10: Outputs are registered. A change on any selection or mode input shows on `ch_pos`/`ch_neg` at the next rising clock edge. A negative select of 1 picks input channel 1 and 0 picks the negative reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_pos | input | CODE_W | Fixed positive channel code of selection A |
| a_neg | input | 1 | Negative select of selection A (1 = channel 1, 0 = negative reference) |
| b_pos | input | CODE_W | Fixed positive channel code of selection B |
| b_neg | input | 1 | Negative select of selection B |
| scan_en | input | 1 | Scan the bitmap for selection A |
| alt_en | input | 1 | Alternate A and B on successive conversions |
| scan_map | input | MAP_W | Channels included in the scan, bit i = code i |
| conv_done | input | 1 | One-cycle pulse: a conversion finished |
| seq_restart | input | 1 | One-cycle pulse: interrupt threshold reached, restart sequence |
| ch_pos | output | CODE_W | Positive channel code for the next conversion |
| ch_neg | output | 1 | Negative select for the next conversion |

## Verification
The conversion-complete pulse and the restart pulse can land in the same cycle, because the threshold is reached on the very conversion that ends. The bench raises both together in directed cases: during a selection-A turn in the middle of a scan, and during a B turn in alternate mode. A random phase raises them together as well. A behavioural model, in which restart takes precedence, predicts the channel code and negative select after every edge, and the bench compares the outputs against it each cycle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CODE_W_DEF = 5;
  localparam int MAP_W_DEF  = 18;

  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;
endpackage

// File: rtl/scan_pick.sv
// Finds the lowest set bitmap bit at or above the cursor, wrapping to the
// lowest set bit overall when none lies above.
module scan_pick #(
  parameter int MAP_W = 18,
  parameter int IDX_W = 5
) (
  input  logic [MAP_W-1:0] map,
  input  logic [IDX_W-1:0] cursor,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [MAP_W-1:0] ge_mask;
  logic [MAP_W-1:0] upper;

  genvar g;
  generate
    for (g = 0; g < MAP_W; g++) begin : g_mask
      assign ge_mask[g] = (IDX_W'(g) >= cursor);
    end
  endgenerate

  assign upper = map & ge_mask;
  assign any   = |map;

  always_comb begin
    idx = '0;
    if (|upper) begin
      for (int i = MAP_W - 1; i >= 0; i--)
        if (upper[i]) idx = IDX_W'(i);
    end else begin
      for (int i = MAP_W - 1; i >= 0; i--)
        if (map[i]) idx = IDX_W'(i);
    end
  end

  // R3: a picked index always points at a selected channel
  always_comb begin
    if (any === 1'b1) a_r3_pick_set: assert (map[idx]);
  end
endmodule

// File: rtl/scan_state.sv
module scan_state
  import adc_scan_pkg::*;
#(
  parameter int MAP_W = 18,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic             seq_restart,
  input  logic             scan_en,
  input  logic             alt_en,
  input  logic             map_any,
  input  logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] cursor_q,
  output logic [IDX_W-1:0] cursor_d,
  output phase_e           phase_q,
  output phase_e           phase_d
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(MAP_W - 1);

  logic is_a;
  assign is_a = !(alt_en && phase_q == PH_B);

  always_comb begin
    cursor_d = cursor_q;
    if (seq_restart)
      cursor_d = '0;
    else if (conv_done && is_a && scan_en && map_any)
      cursor_d = (cur_idx == LAST) ? '0 : cur_idx + 1'b1;
  end

  always_comb begin
    phase_d = phase_q;
    if (seq_restart || !alt_en)
      phase_d = PH_A;
    else if (conv_done)
      phase_d = (phase_q == PH_A) ? PH_B : PH_A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cursor_q <= '0;
      phase_q  <= PH_A;
    end else begin
      cursor_q <= cursor_d;
      phase_q  <= phase_d;
    end
  end

  a_r8_restart_home: assert property (@(posedge clk) disable iff (rst)
    seq_restart |=> (cursor_q == '0 && phase_q == PH_A));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!conv_done && !seq_restart) |=> $stable(cursor_q));

  a_r9_alt_off: assert property (@(posedge clk) disable iff (rst)
    !alt_en |=> phase_q == PH_A);

  a_r6_toggle: assert property (@(posedge clk) disable iff (rst)
    (alt_en && conv_done && !seq_restart) |=> phase_q != $past(phase_q));

  a_r4_cursor_range: assert property (@(posedge clk) disable iff (rst)
    cursor_q < IDX_W'(MAP_W));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int MAP_W  = MAP_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] a_pos,
  input  logic              a_neg,
  input  logic [CODE_W-1:0] b_pos,
  input  logic              b_neg,
  input  logic              scan_en,
  input  logic              alt_en,
  input  logic [MAP_W-1:0]  scan_map,
  input  logic              conv_done,
  input  logic              seq_restart,
  output logic [CODE_W-1:0] ch_pos,
  output logic              ch_neg
);
  localparam int IDX_W = $clog2(MAP_W);

  logic [IDX_W-1:0] cursor_q, cursor_d, cur_idx, nxt_idx;
  logic             cur_any, nxt_any;
  phase_e           phase_q, phase_d;
  logic             use_b;
  logic [CODE_W-1:0] pos_d;
  logic              neg_d;

  scan_pick #(.MAP_W(MAP_W), .IDX_W(IDX_W)) u_pick_cur (
    .map(scan_map), .cursor(cursor_q), .any(cur_any), .idx(cur_idx));

  scan_pick #(.MAP_W(MAP_W), .IDX_W(IDX_W)) u_pick_nxt (
    .map(scan_map), .cursor(cursor_d), .any(nxt_any), .idx(nxt_idx));

  scan_state #(.MAP_W(MAP_W), .IDX_W(IDX_W)) u_state (
    .clk(clk), .rst(rst), .conv_done(conv_done), .seq_restart(seq_restart),
    .scan_en(scan_en), .alt_en(alt_en), .map_any(cur_any), .cur_idx(cur_idx),
    .cursor_q(cursor_q), .cursor_d(cursor_d), .phase_q(phase_q), .phase_d(phase_d));

  assign use_b = alt_en && (phase_d == PH_B);

  always_comb begin
    if (use_b) begin
      pos_d = b_pos;
      neg_d = b_neg;
    end else begin
      pos_d = (scan_en && nxt_any) ? CODE_W'(nxt_idx) : a_pos;
      neg_d = a_neg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_pos <= '0;
      ch_neg <= 1'b0;
    end else begin
      ch_pos <= pos_d;
      ch_neg <= neg_d;
    end
  end

  a_r2_fixed_a: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !alt_en) |=> (ch_pos == $past(a_pos) && ch_neg == $past(a_neg)));

  a_r5_empty_map: assert property (@(posedge clk) disable iff (rst)
    (scan_en && !alt_en && scan_map == '0) |=> ch_pos == $past(a_pos));

  a_r6_b_fixed: assert property (@(posedge clk) disable iff (rst)
    (alt_en && phase_d == PH_B) |=> (ch_pos == $past(b_pos) && ch_neg == $past(b_neg)));

  a_r3_scan_hit: assert property (@(posedge clk) disable iff (rst)
    (scan_en && !alt_en && scan_map != '0) |=>
      ((($past(scan_map)) >> ch_pos) & MAP_W'(1)) != '0);
endmodule

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
module adc_scan_seq_bench;
  localparam int CODE_W = 5;
  localparam int MAP_W  = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CODE_W-1:0] a_pos = '0, b_pos = '0;
  logic a_neg = 1'b0, b_neg = 1'b0;
  logic scan_en = 1'b0, alt_en = 1'b0;
  logic [MAP_W-1:0] scan_map = '0;
  logic conv_done = 1'b0, seq_restart = 1'b0;
  logic [CODE_W-1:0] ch_pos;
  logic ch_neg;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_cur = 0;
  int m_ph = 0;
  int e_pos = 0;
  int e_neg = 0;

  always #4 clk = ~clk;

  adc_scan_seq #(.CODE_W(CODE_W), .MAP_W(MAP_W)) u_adc_scan_seq (
    .clk(clk), .rst(rst), .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
    .scan_en(scan_en), .alt_en(alt_en), .scan_map(scan_map),
    .conv_done(conv_done), .seq_restart(seq_restart), .ch_pos(ch_pos), .ch_neg(ch_neg));

  function automatic int first_sel(input logic [MAP_W-1:0] m, input int from);
    for (int i = from; i < MAP_W; i++) if (m[i]) return i;
    for (int i = 0; i < MAP_W; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic model_edge();
    int k;
    bit now_b;
    if (rst) begin
      m_cur = 0; m_ph = 0; e_pos = 0; e_neg = 0;
      return;
    end
    now_b = alt_en && (m_ph == 1);
    if (seq_restart) begin
      m_cur = 0; m_ph = 0;
    end else begin
      if (conv_done && !now_b && scan_en) begin
        k = first_sel(scan_map, m_cur);
        if (k >= 0) m_cur = (k == MAP_W - 1) ? 0 : k + 1;
      end
      if (!alt_en) m_ph = 0;
      else if (conv_done) m_ph = 1 - m_ph;
    end
    if (alt_en && m_ph == 1) begin
      e_pos = b_pos; e_neg = b_neg;
    end else begin
      k = first_sel(scan_map, m_cur);
      e_pos = (scan_en && k >= 0) ? k : a_pos;
      e_neg = a_neg;
    end
  endtask

  task automatic cyc();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (int'(ch_pos) != e_pos || int'(ch_neg) != e_neg) begin
      errors++;
      $display("FAIL %s: ch_pos=%0d ch_neg=%0d expected ch_pos=%0d ch_neg=%0d at %0t",
               cur_req, ch_pos, ch_neg, e_pos, e_neg, $time);
    end
  endtask

  task automatic pulse_done(input int n);
    for (int i = 0; i < n; i++) begin
      conv_done = 1'b1; cyc();
      conv_done = 1'b0; cyc();
    end
  endtask

  task automatic restart();
    seq_restart = 1'b1; cyc();
    seq_restart = 1'b0; cyc();
  endtask

  initial begin
    cur_req = "R1";
    a_pos = 5'd9; a_neg = 1'b1;
    cyc(); cyc(); cyc();
    rst = 1'b0;
    a_pos = '0; a_neg = 1'b0;
    cyc();

    cur_req = "R2";
    a_pos = 5'd7; a_neg = 1'b1; b_pos = 5'd12; b_neg = 1'b0;
    pulse_done(4);

    cur_req = "R10";
    a_pos = 5'd11; cyc();
    a_neg = 1'b0; cyc();

    cur_req = "R3";
    scan_map = 18'h30024;   // bits 2, 5, 16, 17
    scan_en = 1'b1;
    restart();
    pulse_done(3);
    cur_req = "R4";
    pulse_done(3);

    cur_req = "R5";
    scan_map = '0;
    pulse_done(3);

    cur_req = "R6";
    scan_map = 18'h0001A;   // bits 1, 3, 4
    alt_en = 1'b1; b_neg = 1'b1;
    restart();
    pulse_done(4);
    cur_req = "R7";
    cyc(); cyc(); cyc();
    pulse_done(5);

    cur_req = "R8";
    restart();
    pulse_done(1);           // now on B turn
    conv_done = 1'b1; seq_restart = 1'b1; cyc();
    conv_done = 1'b0; seq_restart = 1'b0; cyc();
    alt_en = 1'b0;
    pulse_done(2);
    conv_done = 1'b1; seq_restart = 1'b1; cyc();
    conv_done = 1'b0; seq_restart = 1'b0; cyc();

    cur_req = "R9";
    alt_en = 1'b1; restart();
    pulse_done(1);           // B turn pending
    alt_en = 1'b0; cyc();
    pulse_done(3);

    cur_req = "R3";
    for (int n = 0; n < 4000; n++) begin
      conv_done   = ($urandom_range(0, 2) == 0);
      seq_restart = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 63) == 0) scan_map = MAP_W'($urandom);
      if ($urandom_range(0, 127) == 0) scan_en = ~scan_en;
      if ($urandom_range(0, 127) == 0) alt_en = ~alt_en;
      if ($urandom_range(0, 255) == 0) a_pos = CODE_W'($urandom);
      if ($urandom_range(0, 255) == 0) b_pos = CODE_W'($urandom);
      cyc();
    end
    conv_done = 1'b0; seq_restart = 1'b0;
    cyc();

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        finished = 1;
        errors++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule